// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps external events. Each of four input pins is synchronised into the clock domain and watched for a programmable transition. When a channel sees its chosen transition, the value of a free-running counter supplied from outside is stored in that channel's capture register. The same event raises a per-channel flag, and the flag drives an interrupt line whenever its enable bit is set. Software reads the stored times over a simple register port and acknowledges events by writing ones to the flag register.

The last channel is dual-use. A mode bit in the control register chooses whether its pin acts as a capture input or whether the channel works as an output compare. In compare mode the channel's pin is ignored, a match between the counter and a compare register sets the same flag, and an output level toggles. The counter itself and interrupt routing live outside this block.

Top module: `icap_unit`

## Requirements
- R1: A detected edge loads the `count` value of the detection cycle into that channel's capture register (addresses 0 to 3). A pin change applied before clock edge k is registered at edge k, reaches the detector at edge k+1, and the capture register shows the `count` present between edges k+1 and k+2 from edge k+2 on.
- R2: Control register at address 4 holds, for channel i, a 2-bit edge select in bits [2i+1:2i]: 00 no capture, 01 low-to-high only, 10 high-to-low only, 11 both transitions. Bit 8 is the mode bit of channel 3. All other bits read 0.
- R3: Every capture event sets flag bit i of the flag register at address 6 (bits 3:0) on the same edge that loads the capture register.
- R4: `irq[i]` is high exactly when flag i and enable bit i (address 5, bits 3:0) are both 1.
- R5: Writing address 6 clears each flag whose written bit is 1; bits written 0 leave their flag unchanged; an event in the same cycle as a clear leaves the flag set.
- R6: Channel 3 captures only while the mode bit (address 4 bit 8) is 1; with it 0, pin 3 transitions change neither capture register 3 nor flag 3.
- R7: With the mode bit 0, a cycle in which `count` equals the compare register (address 7, 16 bits, read/write) sets flag 3 and toggles `oc_out` on the next edge; `oc_oe` is the inverse of the mode bit. With the mode bit 1, no compare match has any effect.
- R8: A new capture overwrites the capture register even while its flag is still set.
- R9: After reset every register and `oc_out` are 0 and `oc_oe` is 1; writes to addresses 0 to 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count | input | 16 | Free-running counter value |
| cap_pin | input | 4 | Asynchronous event pins, one per channel |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 4 | Per-channel interrupt requests |
| oc_out | output | 1 | Compare output level of channel 3 |
| oc_oe | output | 1 | High while channel 3 drives its pin as a compare output |

## Verification
Directed patterns raise and then lower all four pins together with a mixed edge-select setting, which separates rising-only, falling-only and any-edge channels from one another in a single pass, and exact captured times confirm the two-stage synchronisation latency. A disabled channel and channel 3 in compare mode are toggled to show that their pins are ignored, while a compare value a few counts ahead shows the match path setting the shared flag. A long random phase with random pins, control writes and flag clears exercises overlap of clears with new events and overwrites of pending captures, with a cycle-accurate reference model checking every output on every clock.

// File: rtl/icap_pkg.sv
package icap_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/icap_edge.sv
module icap_edge
    import icap_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       lvl,
    input  logic [NCH-1:0][1:0]  sel,
    input  logic [NCH-1:0]       gate,
    output logic [NCH-1:0]       ev
);
    logic [NCH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic up, down;
        assign up   = lvl[ch] & ~prev_q[ch];
        assign down = ~lvl[ch] & prev_q[ch];
        always_comb begin
            unique case (edge_sel_e'(sel[ch]))
                EDGE_RISE: ev[ch] = gate[ch] & up;
                EDGE_FALL: ev[ch] = gate[ch] & down;
                EDGE_ANY:  ev[ch] = gate[ch] & (up | down);
                default:   ev[ch] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
    parameter int NCH  = 4,
    parameter int CW   = 16,
    parameter int SYNC = 2,
    localparam int AW  = $clog2(NCH + 4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [NCH-1:0] cap_pin,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic [NCH-1:0] irq,
    output logic          oc_out,
    output logic          oc_oe
);
    localparam int LAST = NCH - 1;
    localparam logic [AW-1:0] CTL_A = AW'(NCH);
    localparam logic [AW-1:0] EN_A  = AW'(NCH + 1);
    localparam logic [AW-1:0] FLG_A = AW'(NCH + 2);
    localparam logic [AW-1:0] CMP_A = AW'(NCH + 3);

    typedef struct packed {
        logic [NCH-1:0][CW-1:0] cap;
        logic [NCH-1:0][1:0]    sel;
        logic                   capsel;
        logic [NCH-1:0]         en;
        logic [NCH-1:0]         flag;
        logic [CW-1:0]          cmp;
        logic                   oc;
    } st_t;

    st_t st_d, st_q;

    logic [NCH-1:0] pin_sync;
    logic [NCH-1:0] gate;
    logic [NCH-1:0] cap_ev;
    logic [NCH-1:0] flag_ev;
    logic [NCH-1:0] clr;
    logic           cmp_hit;

    icap_sync #(.W(NCH), .STAGES(SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cap_pin),
        .q     (pin_sync)
    );

    assign gate = {st_q.capsel, {(NCH-1){1'b1}}};

    icap_edge #(.NCH(NCH)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pin_sync),
        .sel   (st_q.sel),
        .gate  (gate),
        .ev    (cap_ev)
    );

    always_comb begin
        st_d    = st_q;
        clr     = '0;
        cmp_hit = !st_q.capsel && (count == st_q.cmp);
        flag_ev = cap_ev;
        flag_ev[LAST] = cap_ev[LAST] | cmp_hit;

        if (bus_wr) begin
            if (bus_addr == CTL_A) begin
                st_d.sel    = bus_wdata[2*NCH-1:0];
                st_d.capsel = bus_wdata[2*NCH];
            end
            if (bus_addr == EN_A)  st_d.en  = bus_wdata[NCH-1:0];
            if (bus_addr == FLG_A) clr      = bus_wdata[NCH-1:0];
            if (bus_addr == CMP_A) st_d.cmp = bus_wdata;
        end

        for (int ch = 0; ch < NCH; ch++) begin
            if (cap_ev[ch]) st_d.cap[ch] = count;
        end

        if (cmp_hit) st_d.oc = ~st_q.oc;
        st_d.flag = (st_q.flag & ~clr) | flag_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (bus_addr == AW'(ch)) bus_rdata = st_q.cap[ch];
        end
        if (bus_addr == CTL_A) bus_rdata[2*NCH:0]  = {st_q.capsel, st_q.sel};
        if (bus_addr == EN_A)  bus_rdata[NCH-1:0]  = st_q.en;
        if (bus_addr == FLG_A) bus_rdata[NCH-1:0]  = st_q.flag;
        if (bus_addr == CMP_A) bus_rdata           = st_q.cmp;
    end

    assign irq    = st_q.flag & st_q.en;
    assign oc_out = st_q.oc;
    assign oc_oe  = ~st_q.capsel;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int AW  = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [CW-1:0]          count,
    input logic [NCH-1:0]         cap_ev,
    input logic [NCH-1:0]         flag_ev,
    input logic [NCH-1:0][CW-1:0] cap,
    input logic [NCH-1:0]         flag,
    input logic                   capsel,
    input logic [CW-1:0]          cmp,
    input logic                   oc_out,
    input logic                   bus_wr,
    input logic [AW-1:0]          bus_addr,
    input logic [CW-1:0]          bus_wdata
);
    localparam logic [AW-1:0] FLG_A = AW'(NCH + 2);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        p_cap_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
            cap_ev[ch] |=> cap[ch] == $past(count));

        p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            flag_ev[ch] |=> flag[ch]);

        p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == FLG_A && bus_wdata[ch] && !flag_ev[ch]) |=> !flag[ch]);

        p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_ev[ch] |=> $stable(cap[ch]));
    end

    p_oc_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!capsel && count == cmp) |=> oc_out != $past(oc_out));

    p_oc_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capsel |=> $stable(oc_out));
endmodule

bind icap_unit icap_unit_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .cap_ev    (cap_ev),
    .flag_ev   (flag_ev),
    .cap       (st_q.cap),
    .flag      (st_q.flag),
    .capsel    (st_q.capsel),
    .cmp       (st_q.cmp),
    .oc_out    (oc_out),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/icap_unit_test.sv
module icap_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = 16'h1000;
    logic [3:0]  pins = 4'h0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [3:0]  irq;
    logic        oc_out, oc_oe;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [2:0] rot = 3'd0;

    always #2 clk = ~clk;

    icap_unit uut (
        .clk(clk), .rst_n(rst_n), .count(cnt), .cap_pin(pins),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .oc_out(oc_out), .oc_oe(oc_oe)
    );

    // reference model
    logic [15:0] m_cap [4];
    logic [7:0]  m_sel;
    logic        m_capsel;
    logic [3:0]  m_en, m_flag;
    logic [15:0] m_cmp;
    logic        m_oc;
    logic [3:0]  hist [$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_cap[i] = 16'h0;
            m_sel = 8'h0; m_capsel = 1'b0; m_en = 4'h0; m_flag = 4'h0;
            m_cmp = 16'h0; m_oc = 1'b0;
            hist = '{4'h0, 4'h0, 4'h0};
        end else begin
            logic [3:0] ev, wipe;
            ev = 4'h0;
            for (int ch = 0; ch < 4; ch++) begin
                logic was, now_l, hit;
                logic [1:0] s;
                was = hist[2][ch];
                now_l = hist[1][ch];
                s = m_sel[2*ch +: 2];
                hit = (s == 2'b01 && !was && now_l) || (s == 2'b10 && was && !now_l)
                      || (s == 2'b11 && was != now_l);
                if (ch == 3 && !m_capsel) hit = 1'b0;
                if (hit) begin ev[ch] = 1'b1; m_cap[ch] = cnt; end
            end
            if (!m_capsel && cnt == m_cmp) begin ev[3] = 1'b1; m_oc = !m_oc; end
            wipe = (bus_wr && bus_addr == 3'd6) ? bus_wdata[3:0] : 4'h0;
            m_flag = (m_flag & ~wipe) | ev;
            if (bus_wr) begin
                if (bus_addr == 3'd4) begin m_sel = bus_wdata[7:0]; m_capsel = bus_wdata[8]; end
                if (bus_addr == 3'd5) m_en = bus_wdata[3:0];
                if (bus_addr == 3'd7) m_cmp = bus_wdata;
            end
            hist.push_front(pins);
            void'(hist.pop_back());
        end
    end

    function automatic logic [15:0] exp_rd(logic [2:0] a);
        case (a)
            3'd4:    return {7'h0, m_capsel, m_sel};
            3'd5:    return {12'h0, m_en};
            3'd6:    return {12'h0, m_flag};
            3'd7:    return m_cmp;
            default: return m_cap[a[1:0]];
        endcase
    endfunction

    function automatic string addr_tag(logic [2:0] a);
        case (a)
            3'd4:    return "R2";
            3'd5:    return "R4";
            3'd6:    return "R3/R5";
            3'd7:    return "R7";
            default: return "R1/R8";
        endcase
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, expv, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(addr_tag(bus_addr), bus_rdata, exp_rd(bus_addr));
            chk("R4 irq", {12'h0, irq}, {12'h0, m_flag & m_en});
            chk("R7 oc_out", {15'h0, oc_out}, {15'h0, m_oc});
            chk("R7 oc_oe", {15'h0, oc_oe}, {15'h0, !m_capsel});
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic tick();
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = rot;
        rot = rot + 3'd1;
        cnt = cnt + 16'd1;
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cnt = cnt + 16'd1;
    endtask

    task automatic rd(logic [2:0] a, logic [15:0] expv, string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        cnt = cnt + 16'd1;
        @(posedge clk);
        #1;
        chk(tag, bus_rdata, expv);
    endtask

    // drive pins; returns the counter value the capture should hold
    task automatic set_pins(logic [3:0] v, output logic [15:0] stamp);
        @(negedge clk);
        bus_wr = 1'b0; pins = v;
        cnt = cnt + 16'd1;
        stamp = cnt + 16'd2;
        repeat (4) tick();
    endtask

    initial begin
        logic [15:0] t_up, t_dn, t_again, keep3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        for (int a = 0; a < 8; a++) rd(3'(a), 16'h0, "R9 reset value");
        chk("R9 oc_oe after reset", {15'h0, oc_oe}, 16'h1);

        // R9 capture registers are read-only
        wr(3'd0, 16'hBEEF);
        rd(3'd0, 16'h0, "R9 capture write ignored");

        // R2 mixed edge selects, channel 3 in capture mode
        wr(3'd4, 16'h01F9);
        wr(3'd5, 16'h000F);
        rd(3'd4, 16'h01F9, "R2 control readback");

        set_pins(4'hF, t_up);
        rd(3'd0, t_up, "R1 rising capture ch0");
        rd(3'd1, 16'h0, "R2 falling-only ch1 ignores rise");
        rd(3'd2, t_up, "R2 any-edge ch2 on rise");
        rd(3'd3, t_up, "R6 ch3 captures in capture mode");
        rd(3'd6, 16'h000D, "R3 flags after rise");
        chk("R4 irq after rise", {12'h0, irq}, 16'h000D);

        set_pins(4'h0, t_dn);
        rd(3'd0, t_up, "R2 rising-only ch0 ignores fall");
        rd(3'd1, t_dn, "R1 falling capture ch1");
        rd(3'd2, t_dn, "R8 overwrite while flag set ch2");

        // R5 zero bits do not clear, ones do
        wr(3'd6, 16'h0000);
        rd(3'd6, 16'h000F, "R5 zero write leaves flags");
        wr(3'd6, 16'h0005);
        rd(3'd6, 16'h000A, "R5 clear bits 0 and 2");

        // R8 overwrite ch0 while its flag is set
        set_pins(4'h1, t_again);
        rd(3'd0, t_again, "R1 second capture ch0");
        set_pins(4'h0, t_dn);
        set_pins(4'h1, t_again);
        rd(3'd0, t_again, "R8 overwrite ch0 with flag pending");

        // R2 disabled channel 2
        wr(3'd6, 16'h000F);
        wr(3'd4, 16'h01C9);
        set_pins(4'h5, t_up);
        set_pins(4'h1, t_dn);
        rd(3'd6, 16'h0000, "R2 disabled ch2 raises no flag");

        // R6 channel 3 compare mode ignores pin
        keep3 = 16'h0;
        wr(3'd3, 16'h0);
        rd(3'd3, m_cap[3], "R6 ch3 before compare mode");
        keep3 = bus_rdata;
        wr(3'd7, 16'hFFF0);
        wr(3'd4, 16'h00C9);
        wr(3'd6, 16'h000F);
        set_pins(4'h9, t_up);
        set_pins(4'h1, t_dn);
        rd(3'd3, keep3, "R6 ch3 pin ignored in compare mode");
        rd(3'd6, 16'h0000, "R6 no flag from pin in compare mode");

        // R7 compare match
        wr(3'd7, cnt + 16'd6);
        repeat (8) tick();
        rd(3'd6, 16'h0008, "R7 compare match sets flag 3");
        chk("R7 oc_out toggled", {15'h0, oc_out}, 16'h1);
        chk("R7 oc_oe in compare mode", {15'h0, oc_oe}, 16'h1);

        // random phase, model checked every cycle
        for (int n = 0; n < 2000; n++) begin
            int r;
            r = $urandom_range(0, 15);
            @(negedge clk);
            bus_wr = 1'b0;
            bus_addr = rot; rot = rot + 3'd1;
            cnt = ($urandom_range(0, 7) == 0) ? 16'($urandom) : cnt + 16'd1;
            if (r < 5) pins = 4'($urandom);
            if (r == 5) begin bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 16'($urandom); end
            if (r == 6 && n % 4 == 0) begin bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 16'($urandom); end
            if (r == 7) begin bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 16'($urandom); end
            if (r == 8) begin bus_wr = 1'b1; bus_addr = 3'd7; bus_wdata = cnt + 16'd2; end
        end
        repeat (2) tick();
        finish_run();
    end
endmodule